// File: doc/BRIEF.md
# Interval Timer Counter Channel

This block is a single channel of a programmable interval timer. A host programs an operating mode, then writes a 16-bit initial count. The channel counts prescaled ticks, arriving as a one-cycle clock enable, and drives an output whose waveform depends on the mode. The six modes are: terminal-count flag, retriggerable one-shot, rate pulse, square wave, software strobe and gate-triggered strobe. A gate input either suspends counting or restarts it, depending on the mode.

The live count is shown on a 16-bit port. A snapshot register lets a bus interface freeze the count and read it later. Counting is binary only. The decimal-mode flag is stored and reported, but it does not change the arithmetic. Bus decoding and interrupt delivery are outside this block.

In the text below, N is the initial count in effect and d is the number of ticks counted since the last restart.

Top module: `tmr_channel`

## Requirements
- R1: After reset, `programmed` is 0, `mode_cfg` is 0, `out_sig` is 0, `count_val` is 0 (an initial count of 65536) and `snap_held` is 0. While unprogrammed, the output stays low and ticks do not advance the count, even after a load.
- R2: A load stores N = `load_val`, or 65536 when `load_val` is 0. From the next clock edge, `count_val` equals `load_val` and d restarts at 0. A tick in the same cycle as a load is discarded. A load while counting takes effect at once, without waiting for the current period to end.
- R3: A program strobe stores the mode and the decimal flag. Mode codes 0 to 5 are kept as written, 6 reads back as 2 and 7 as 3. Programming restarts d at 0 and stops counting until the next load.
- R4: Mode 0: `out_sig` is 1 exactly when d >= N, so it stays high until the channel is programmed again.
- R5: Mode 1: `out_sig` is 1 exactly when d < N.
- R6: Mode 2: the count shows N - (d mod N), and `out_sig` is 1 exactly when d mod N = 0 and d != 0. There is no pulse right after a load.
- R7: Mode 3: the count shows N - ((2d) mod N), and `out_sig` is 1 exactly when (d mod N) < (N+1)/2, with integer division.
- R8: Modes 4 and 5: `out_sig` is 1 only while d = N, so the pulse lasts one tick.
- R9: In modes 0, 1, 4 and 5 the count shows (N - d) mod 65536, and it keeps wrapping after terminal count.
- R10: `gate_in` is sampled by a register on every clock. In modes 0 and 4, ticks advance d only while the sampled gate is 1. In modes 1, 2, 3 and 5, a 0-to-1 change between two consecutive samples restarts d at 0 on the following edge. In those modes the gate level itself never stops counting.
- R11: `snap_req` copies the current count into `snap_val` and sets `snap_held`. Further requests are ignored while `snap_held` is 1. `snap_clr` clears `snap_held` and takes priority over a request in the same cycle.
- R12: In a cycle with no tick, no load, no program strobe and no gate restart, `count_val` and `out_sig` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count enable, one cycle per counter tick |
| gate_in | input | 1 | Gate level |
| prog | input | 1 | Program strobe for mode and decimal flag |
| prog_mode | input | 3 | Mode code written with `prog` |
| prog_bcd | input | 1 | Decimal flag written with `prog` |
| load | input | 1 | Initial-count strobe |
| load_val | input | CNT_W | Initial count (0 means 65536) |
| snap_req | input | 1 | Capture the count into the snapshot |
| snap_clr | input | 1 | Release the snapshot |
| count_val | output | CNT_W | Live count |
| out_sig | output | 1 | Channel output |
| mode_cfg | output | 3 | Stored mode after folding codes 6 and 7 |
| bcd_cfg | output | 1 | Stored decimal flag |
| programmed | output | 1 | A mode has been programmed since reset |
| snap_val | output | CNT_W | Snapshot of the count |
| snap_held | output | 1 | Snapshot holds a value |

## Verification
A wrong tick position, such as a dropped or doubled advance or a wrap off by one, changes `count_val` in the very cycle after the faulty edge. Comparing the count on every clock therefore locates such a fault to a single tick. Errors in the out-level decode, such as a mode 4/5 pulse that lasts one tick too long or a mode 3 half-period with odd N, appear only at period boundaries. The stimulus therefore runs several full periods for both even and odd N. Gate faults show up as a restart that comes one clock early or late relative to the two-edge sampling rule, or as a mode 0/4 count that moves while the gate is low.

// File: rtl/tmr_chan_pkg.sv
package tmr_chan_pkg;

  typedef enum logic [2:0] {
    MD_TERM    = 3'd0,
    MD_ONESHOT = 3'd1,
    MD_RATE    = 3'd2,
    MD_SQUARE  = 3'd3,
    MD_SWSTB   = 3'd4,
    MD_HWSTB   = 3'd5
  } tmr_mode_e;

  // codes 6 and 7 fold onto the rate and square modes
  function automatic tmr_mode_e fold_mode(input logic [2:0] raw);
    if (raw[2] && raw[1]) return tmr_mode_e'({1'b0, raw[1:0]});
    return tmr_mode_e'(raw);
  endfunction

  function automatic logic gate_retrig(input tmr_mode_e m);
    return (m == MD_ONESHOT) || (m == MD_RATE) || (m == MD_SQUARE) || (m == MD_HWSTB);
  endfunction

  function automatic logic gate_holds(input tmr_mode_e m);
    return (m == MD_TERM) || (m == MD_SWSTB);
  endfunction

endpackage

// File: rtl/tmr_gate_sync.sv
module tmr_gate_sync #(
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic gate_in,
  output logic gate_lvl,
  output logic gate_rise
);

  logic smp_q, prv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_q <= RST_VAL;
      prv_q <= RST_VAL;
    end else begin
      smp_q <= gate_in;
      prv_q <= smp_q;
    end
  end

  assign gate_lvl  = smp_q;
  assign gate_rise = smp_q & ~prv_q;

endmodule

// File: rtl/tmr_mode_ctrl.sv
module tmr_mode_ctrl
  import tmr_chan_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       prog,
  input  logic [2:0] prog_mode,
  input  logic       prog_bcd,
  input  logic       load,
  input  logic       tick,
  input  logic       gate_lvl,
  input  logic       gate_rise,
  output tmr_mode_e  mode_q,
  output logic       programmed_q,
  output logic       bcd_q,
  output logic       restart,
  output logic       advance
);

  tmr_mode_e mode_d;
  logic      prog_d, bcd_d, run_d, run_q;
  logic      retrig_hit;

  always_comb begin
    mode_d = mode_q;
    prog_d = programmed_q;
    bcd_d  = bcd_q;
    run_d  = run_q;
    if (prog) begin
      mode_d = fold_mode(prog_mode);
      prog_d = 1'b1;
      bcd_d  = prog_bcd;
      run_d  = 1'b0;
    end else if (load) begin
      run_d  = programmed_q;
    end
  end

  always_comb begin
    retrig_hit = programmed_q && gate_retrig(mode_q) && gate_rise;
    restart    = prog || load || retrig_hit;
    advance    = tick && run_q && !restart && (!gate_holds(mode_q) || gate_lvl);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q       <= MD_TERM;
      programmed_q <= 1'b0;
      bcd_q        <= 1'b0;
      run_q        <= 1'b0;
    end else begin
      mode_q       <= mode_d;
      programmed_q <= prog_d;
      bcd_q        <= bcd_d;
      run_q        <= run_d;
    end
  end

endmodule

// File: rtl/tmr_elapsed.sv
module tmr_elapsed #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         restart,
  input  logic         advance,
  output logic [W:0]   init_q,
  output logic [W-1:0] cnt_q,
  output logic [W:0]   rem_q,
  output logic         past_q,
  output logic [W:0]   ph_q,
  output logic         moved_q
);

  localparam int NW = W + 1;
  localparam logic [NW-1:0] FULL = {1'b1, {W{1'b0}}};

  logic [NW-1:0] new_n, n_sel, init_d, rem_d, ph_d, ph_inc;
  logic [W-1:0]  cnt_d;
  logic          past_d, moved_d;

  always_comb begin
    new_n  = (load_val == '0) ? FULL : {1'b0, load_val};
    n_sel  = load ? new_n : init_q;
    init_d = load ? new_n : init_q;
    ph_inc = ph_q + 1'b1;
    cnt_d   = cnt_q;
    rem_d   = rem_q;
    past_d  = past_q;
    ph_d    = ph_q;
    moved_d = moved_q;
    if (restart) begin
      cnt_d   = n_sel[W-1:0];
      rem_d   = n_sel;
      past_d  = 1'b0;
      ph_d    = '0;
      moved_d = 1'b0;
    end else if (advance) begin
      cnt_d   = cnt_q - 1'b1;
      rem_d   = (rem_q == '0) ? '0 : rem_q - 1'b1;
      past_d  = past_q || (rem_q == '0);
      ph_d    = (ph_inc == init_q) ? '0 : ph_inc;
      moved_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_q  <= FULL;
      cnt_q   <= '0;
      rem_q   <= FULL;
      past_q  <= 1'b0;
      ph_q    <= '0;
      moved_q <= 1'b0;
    end else begin
      init_q  <= init_d;
      cnt_q   <= cnt_d;
      rem_q   <= rem_d;
      past_q  <= past_d;
      ph_q    <= ph_d;
      moved_q <= moved_d;
    end
  end

endmodule

// File: rtl/tmr_outsel.sv
module tmr_outsel
  import tmr_chan_pkg::*;
#(
  parameter int W = 16
) (
  input  tmr_mode_e    mode,
  input  logic         programmed,
  input  logic [W:0]   init_n,
  input  logic [W-1:0] cnt,
  input  logic [W:0]   rem,
  input  logic         past,
  input  logic [W:0]   ph,
  input  logic         moved,
  output logic [W-1:0] count_val,
  output logic         out_sig
);

  localparam int NW = W + 1;

  logic [NW:0]   init_x, twice, twice_mod, half;
  logic [NW-1:0] rate_cnt, sq_cnt;
  logic          sq_hi;

  always_comb begin
    init_x    = {1'b0, init_n};
    twice     = {ph, 1'b0};
    twice_mod = (twice >= init_x) ? twice - init_x : twice;
    half      = (init_x + 1'b1) >> 1;
    sq_hi     = ({1'b0, ph} < half);
    rate_cnt  = init_n - ph;
    sq_cnt    = init_n - twice_mod[NW-1:0];
  end

  always_comb begin
    unique case (mode)
      MD_RATE:   count_val = rate_cnt[W-1:0];
      MD_SQUARE: count_val = sq_cnt[W-1:0];
      default:   count_val = cnt;
    endcase
  end

  always_comb begin
    if (!programmed) begin
      out_sig = 1'b0;
    end else begin
      unique case (mode)
        MD_TERM:    out_sig = (rem == '0);
        MD_ONESHOT: out_sig = (rem != '0);
        MD_RATE:    out_sig = (ph == '0) && moved;
        MD_SQUARE:  out_sig = sq_hi;
        default:    out_sig = (rem == '0) && !past;
      endcase
    end
  end

endmodule

// File: rtl/tmr_snap.sv
module tmr_snap #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         snap_req,
  input  logic         snap_clr,
  input  logic [W-1:0] live,
  output logic [W-1:0] snap_val,
  output logic         snap_held
);

  logic [W-1:0] val_d;
  logic         held_d;

  always_comb begin
    val_d  = snap_val;
    held_d = snap_held;
    if (snap_clr) begin
      held_d = 1'b0;
    end else if (snap_req && !snap_held) begin
      val_d  = live;
      held_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_val  <= '0;
      snap_held <= 1'b0;
    end else begin
      snap_val  <= val_d;
      snap_held <= held_d;
    end
  end

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_chan_pkg::*;
#(
  parameter int   CNT_W    = 16,
  parameter logic GATE_RST = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             gate_in,
  input  logic             prog,
  input  logic [2:0]       prog_mode,
  input  logic             prog_bcd,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             snap_req,
  input  logic             snap_clr,
  output logic [CNT_W-1:0] count_val,
  output logic             out_sig,
  output logic [2:0]       mode_cfg,
  output logic             bcd_cfg,
  output logic             programmed,
  output logic [CNT_W-1:0] snap_val,
  output logic             snap_held
);

  tmr_mode_e        mode_q;
  logic             gate_lvl, gate_rise, restart, advance;
  logic [CNT_W:0]   init_q, rem_q, ph_q;
  logic [CNT_W-1:0] cnt_q;
  logic             past_q, moved_q;

  tmr_gate_sync #(.RST_VAL(GATE_RST)) u_gate (
    .clk(clk), .rst_n(rst_n), .gate_in(gate_in),
    .gate_lvl(gate_lvl), .gate_rise(gate_rise)
  );

  tmr_mode_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .prog(prog), .prog_mode(prog_mode),
    .prog_bcd(prog_bcd), .load(load), .tick(tick),
    .gate_lvl(gate_lvl), .gate_rise(gate_rise),
    .mode_q(mode_q), .programmed_q(programmed), .bcd_q(bcd_cfg),
    .restart(restart), .advance(advance)
  );

  tmr_elapsed #(.W(CNT_W)) u_elapsed (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val),
    .restart(restart), .advance(advance),
    .init_q(init_q), .cnt_q(cnt_q), .rem_q(rem_q), .past_q(past_q),
    .ph_q(ph_q), .moved_q(moved_q)
  );

  tmr_outsel #(.W(CNT_W)) u_outsel (
    .mode(mode_q), .programmed(programmed), .init_n(init_q), .cnt(cnt_q),
    .rem(rem_q), .past(past_q), .ph(ph_q), .moved(moved_q),
    .count_val(count_val), .out_sig(out_sig)
  );

  tmr_snap #(.W(CNT_W)) u_snap (
    .clk(clk), .rst_n(rst_n), .snap_req(snap_req), .snap_clr(snap_clr),
    .live(count_val), .snap_val(snap_val), .snap_held(snap_held)
  );

  assign mode_cfg = mode_q;

endmodule

// File: rtl/tmr_channel_chk.sv
module tmr_channel_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick,
  input logic         prog,
  input logic [2:0]   prog_mode,
  input logic         load,
  input logic [W-1:0] load_val,
  input logic         snap_clr,
  input logic [W-1:0] count_val,
  input logic         out_sig,
  input logic [2:0]   mode_cfg,
  input logic         programmed,
  input logic [W-1:0] snap_val,
  input logic         snap_held,
  input logic         gate_lvl,
  input logic         gate_rise
);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !programmed |-> !out_sig);

  p_load_shows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !prog) |=> (count_val == $past(load_val)));

  p_mode_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    programmed |-> (mode_cfg <= 3'd5));

  p_mode_fold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    prog |=> (mode_cfg == (($past(prog_mode) > 3'd5) ? $past(prog_mode) - 3'd4 : $past(prog_mode))));

  p_term_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (programmed && mode_cfg == 3'd0 && out_sig && !load && !prog) |=> out_sig);

  p_no_load_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !prog && programmed && mode_cfg != 3'd1 && mode_cfg != 3'd3) |=> !out_sig);

  p_strobe_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (programmed && (mode_cfg == 3'd4 || mode_cfg == 3'd5) && out_sig && tick &&
     !load && !prog && !gate_rise && (mode_cfg == 3'd5 || gate_lvl)) |=> !out_sig);

  p_snap_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (snap_held && !snap_clr) |=> ($stable(snap_val) && snap_held));

  p_frozen_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (programmed && !tick && !load && !prog && !gate_rise) |=> ($stable(count_val) && $stable(out_sig)));

endmodule

bind tmr_channel tmr_channel_chk #(.W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .prog(prog), .prog_mode(prog_mode),
  .load(load), .load_val(load_val), .snap_clr(snap_clr),
  .count_val(count_val), .out_sig(out_sig), .mode_cfg(mode_cfg),
  .programmed(programmed), .snap_val(snap_val), .snap_held(snap_held),
  .gate_lvl(gate_lvl), .gate_rise(gate_rise)
);

// File: tb/tmr_channel_test.sv
`timescale 1ns/1ps
module tmr_channel_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0, gate_in = 1'b1, prog = 1'b0, prog_bcd = 1'b0;
  logic [2:0]  prog_mode = 3'd0;
  logic        load = 1'b0, snap_req = 1'b0, snap_clr = 1'b0;
  logic [15:0] load_val = 16'd0;
  logic [15:0] count_val, snap_val;
  logic        out_sig, bcd_cfg, programmed, snap_held;
  logic [2:0]  mode_cfg;

  always #4 clk = ~clk;

  tmr_channel uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .gate_in(gate_in), .prog(prog),
    .prog_mode(prog_mode), .prog_bcd(prog_bcd), .load(load), .load_val(load_val),
    .snap_req(snap_req), .snap_clr(snap_clr), .count_val(count_val),
    .out_sig(out_sig), .mode_cfg(mode_cfg), .bcd_cfg(bcd_cfg),
    .programmed(programmed), .snap_val(snap_val), .snap_held(snap_held)
  );

  int    n_cmp = 0, n_bad = 0;
  string cur_req = "R1";

  // behavioural reference: elapsed ticks d since last restart
  int m_n, m_d, m_mode, m_snapv;
  bit m_prg, m_run, m_bcd, m_g1, m_g2, m_snaph;

  function automatic int ref_count();
    case (m_mode)
      2:       return (m_n - (m_d % m_n)) & 16'hffff;
      3:       return (m_n - ((2 * m_d) % m_n)) & 16'hffff;
      default: return (m_n - m_d) & 16'hffff;
    endcase
  endfunction

  function automatic int ref_out();
    if (!m_prg) return 0;
    case (m_mode)
      0:       return int'(m_d >= m_n);
      1:       return int'(m_d < m_n);
      2:       return int'((m_d % m_n) == 0 && m_d != 0);
      3:       return int'((m_d % m_n) < (m_n + 1) / 2);
      default: return int'(m_d == m_n);
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_n = 65536; m_d = 0; m_mode = 0; m_prg = 0; m_run = 0; m_bcd = 0;
      m_g1 = 1; m_g2 = 1; m_snaph = 0; m_snapv = 0;
    end else begin
      int  cur;
      bit  rise, retrig, lvl_ok;
      cur    = ref_count();
      rise   = m_g1 && !m_g2;
      retrig = m_prg && (m_mode == 1 || m_mode == 2 || m_mode == 3 || m_mode == 5);
      lvl_ok = (m_mode == 0 || m_mode == 4) ? m_g1 : 1'b1;
      if (snap_clr) m_snaph = 0;
      else if (snap_req && !m_snaph) begin m_snapv = cur; m_snaph = 1; end
      if (load) m_n = (load_val == 0) ? 65536 : int'(load_val);
      if (prog) begin
        m_mode = (prog_mode > 5) ? int'(prog_mode) - 4 : int'(prog_mode);
        m_bcd = prog_bcd; m_prg = 1; m_run = 0; m_d = 0;
      end else if (load) begin
        m_run = m_prg; m_d = 0;
      end else if (rise && retrig) begin
        m_d = 0;
      end else if (tick && m_run && lvl_ok) begin
        m_d = m_d + 1;
      end
      m_g2 = m_g1; m_g1 = gate_in;
    end
  end

  task automatic chk(string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    chk("count_val", int'(count_val), ref_count());
    chk("out_sig", int'(out_sig), ref_out());
    chk("mode_cfg", int'(mode_cfg), m_mode);
    chk("programmed", int'(programmed), int'(m_prg));
    chk("bcd_cfg", int'(bcd_cfg), int'(m_bcd));
    chk("snap_held", int'(snap_held), int'(m_snaph));
    chk("snap_val", int'(snap_val), m_snapv);
  end

  task automatic program_mode(int m, bit b);
    @(negedge clk); prog = 1; prog_mode = 3'(m); prog_bcd = b;
    @(negedge clk); prog = 0;
  endtask

  task automatic load_count(int v, bit with_tick);
    @(negedge clk); load = 1; load_val = 16'(v); tick = with_tick;
    @(negedge clk); load = 0; tick = 0;
  endtask

  task automatic ticks(int n, int gap);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1;
      @(negedge clk); tick = 0;
      repeat (gap) @(negedge clk);
    end
  endtask

  task automatic set_gate(bit v);
    @(negedge clk); gate_in = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse_snap(bit req, bit clr);
    @(negedge clk); snap_req = req; snap_clr = clr;
    @(negedge clk); snap_req = 0; snap_clr = 0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    cur_req = "R1";
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    load_count(10, 0);
    ticks(3, 0);

    cur_req = "R4";
    program_mode(0, 0);
    load_count(5, 0);
    ticks(8, 0);
    cur_req = "R9";
    ticks(4, 1);
    cur_req = "R10";
    load_count(6, 0);
    ticks(2, 0);
    set_gate(0);
    ticks(3, 0);
    set_gate(1);
    ticks(5, 0);

    cur_req = "R5";
    program_mode(1, 0);
    load_count(4, 0);
    ticks(6, 0);
    cur_req = "R10";
    set_gate(0);
    ticks(2, 0);
    set_gate(1);
    ticks(5, 0);

    cur_req = "R6";
    program_mode(2, 0);
    load_count(4, 0);
    ticks(10, 1);

    cur_req = "R7";
    program_mode(3, 0);
    load_count(5, 0);
    ticks(12, 0);
    load_count(4, 0);
    ticks(9, 0);

    cur_req = "R3";
    program_mode(6, 1);
    load_count(3, 0);
    ticks(4, 0);
    program_mode(7, 0);
    ticks(2, 0);
    load_count(6, 0);
    ticks(7, 0);

    cur_req = "R8";
    program_mode(4, 0);
    load_count(3, 0);
    ticks(6, 0);
    load_count(3, 0);
    ticks(1, 0);
    set_gate(0);
    ticks(3, 0);
    set_gate(1);
    ticks(4, 0);
    program_mode(5, 0);
    load_count(3, 0);
    ticks(2, 0);
    set_gate(0);
    set_gate(1);
    ticks(6, 0);

    cur_req = "R2";
    program_mode(2, 0);
    load_count(0, 0);
    ticks(5, 0);
    load_count(7, 1);
    ticks(9, 0);
    program_mode(1, 0);
    load_count(0, 0);
    ticks(3, 0);

    cur_req = "R11";
    program_mode(0, 0);
    load_count(20, 0);
    ticks(2, 0);
    pulse_snap(1, 0);
    ticks(3, 0);
    pulse_snap(1, 0);
    ticks(2, 0);
    pulse_snap(1, 1);
    ticks(1, 0);
    pulse_snap(1, 0);
    ticks(2, 0);

    cur_req = "R12";
    program_mode(3, 0);
    load_count(7, 0);
    ticks(10, 3);
    repeat (5) @(negedge clk);
    finish_run();
  end

endmodule